// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block drives a small set of periodic pulse outputs from a free-running 64-bit time value held elsewhere. Software loads a 64-bit start time in two 32-bit halves, writing the low half first and the high half last. It also loads one period word per generator and sets an enable bit. While the trains are held, the block compares the incoming time against the start time on every counter increment. On the first increment at which the time is at or past the start time, every generator emits its first pulse. After that, each generator fires whenever the time reaches its own next-edge time, which advances by the stored period plus the nominal clock period.

Each period word is programmed as the wanted period minus one nominal clock period. The start time is programmed as a whole-second boundary minus one nominal clock period. With those values, each pulse appears at the registered output at the boundary itself. Generator 0 also produces a one-cycle event strobe for interrupt logic placed outside the block. Loading a new start time, or a jump of the time value, silences all trains until a newly loaded start time is reached.

Top module: `alarm_pulse_gen`

## Requirements
- R1: After reset all pulse outputs and the event strobe are low, no start time is loaded, the enable bit is clear and all periods are zero.
- R2: Register writes use `wr_sel`: 0 loads the low start-time word, 1 loads the high start-time word, 2 loads the control word (bit 0 = enable), and 3, 4 and 5 load the period word of generators 0, 1 and 2. A high-word write loads the start time; a low-word write leaves the block with no start time loaded.
- R3: While a start time is loaded and the block is enabled, the first `cnt_tick` cycle with `time_now` >= the start time drives every pulse output high from the next cycle. This consumes the start time, so it fires only once.
- R4: After the start, a generator fires on each `cnt_tick` cycle with `time_now` >= its next-edge time. The first next-edge time is the start time plus (period + `clk_period`), and each firing adds (period + `clk_period`) again.
- R5: A pulse stays high until the next `cnt_tick` cycle on which its generator does not fire, so it lasts one counter increment. With no tick, no write and no time jump, the outputs hold.
- R6: `pulse_ev_o` is high for exactly the cycles that follow a firing of generator 0, and only together with `pulse_o[0]`.
- R7: `NUM_PULSE` is 2 or 3. The third generator exists only at 3 and runs from its own period word.
- R8: A `time_jump` cycle, or any write of either start-time word, clears all pulses in the next cycle. Generators stay silent until a new high-word write is followed by a match.
- R9: Clearing the enable bit silences every generator from the second cycle after the write. While the bit is clear a loaded start time does not match but stays loaded, and it matches once the bit is set again.
- R10: A new period word takes effect at the generator's next firing; the edge already scheduled is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current time value in ns |
| cnt_tick | input | 1 | High in the cycle in which time_now has just advanced |
| time_jump | input | 1 | High in a cycle in which the time was set or stepped |
| clk_period | input | CLKP_W | Nominal time increment per counter tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R2) |
| wr_data | input | 32 | Write data |
| pulse_o | output | NUM_PULSE | Pulse outputs, one per generator |
| pulse_ev_o | output | 1 | Event strobe for each firing of generator 0 |

## Verification
The main function is driven from a cycle-accurate reference model kept in the bench, with counter ticks arriving at random on 80% of cycles so that the time between firings is irregular. A start time just past a 32-bit boundary shows whether both words take part in the compare. A start time already in the past, loaded while the block is disabled, separates "stays loaded while disabled" from "matches on enable". A period change in mid-run separates a reload from a reschedule of the pending edge. Random mixes of time jumps, start-time writes and enable toggles test that every disarm path silences all generators and that none restarts before a new match.

// File: rtl/apg_pkg.sv
package apg_pkg;

    localparam int unsigned TIME_W = 64;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        SEL_ALARM_LO = 3'd0,
        SEL_ALARM_HI = 3'd1,
        SEL_CTRL     = 3'd2,
        SEL_PER0     = 3'd3,
        SEL_PER1     = 3'd4,
        SEL_PER2     = 3'd5
    } apg_sel_e;

    // Select code of the period word of generator idx
    function automatic logic [2:0] per_sel(input int unsigned idx);
        return 3'(int'(SEL_PER0) + int'(idx));
    endfunction

endpackage

// File: rtl/apg_regs.sv
module apg_regs
    import apg_pkg::*;
#(
    parameter int unsigned NUM_PULSE = 2,
    parameter int unsigned PER_W     = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [2:0]                         wr_sel,
    input  logic [WORD_W-1:0]                  wr_data,
    output logic [TIME_W-1:0]                  alarm_o,
    output logic                               enable_o,
    output logic [NUM_PULSE-1:0][PER_W-1:0]    period_o,
    output logic                               lo_wr_o,
    output logic                               hi_wr_o
);

    typedef struct packed {
        logic [WORD_W-1:0]               alarm_lo;
        logic [WORD_W-1:0]               alarm_hi;
        logic                            enable;
        logic [NUM_PULSE-1:0][PER_W-1:0] period;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel == SEL_ALARM_LO) st_d.alarm_lo = wr_data;
            if (wr_sel == SEL_ALARM_HI) st_d.alarm_hi = wr_data;
            if (wr_sel == SEL_CTRL)     st_d.enable   = wr_data[0];
            for (int i = 0; i < int'(NUM_PULSE); i++) begin
                if (wr_sel == per_sel(i)) st_d.period[i] = wr_data[PER_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm_o  = {st_q.alarm_hi, st_q.alarm_lo};
    assign enable_o = st_q.enable;
    assign period_o = st_q.period;
    assign lo_wr_o  = wr_en && (wr_sel == SEL_ALARM_LO);
    assign hi_wr_o  = wr_en && (wr_sel == SEL_ALARM_HI);

endmodule

// File: rtl/apg_arm.sv
module apg_arm
    import apg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic [TIME_W-1:0] time_now,
    input  logic              time_jump,
    input  logic              enable,
    input  logic [TIME_W-1:0] alarm,
    input  logic              lo_wr,
    input  logic              hi_wr,
    output logic              start_o,
    output logic              stop_o
);

    typedef struct packed {
        logic armed;
    } arm_t;

    arm_t st_d, st_q;
    logic stop;
    logic start;

    always_comb begin
        stop  = time_jump || lo_wr || hi_wr || !enable;
        start = st_q.armed && !stop && cnt_tick && (time_now >= alarm);
        st_d  = st_q;
        if (time_jump)  st_d.armed = 1'b0;
        else if (hi_wr) st_d.armed = 1'b1;
        else if (lo_wr) st_d.armed = 1'b0;
        else if (start) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = start;
    assign stop_o  = stop;

endmodule

// File: rtl/apg_chan.sv
module apg_chan
    import apg_pkg::*;
#(
    parameter int unsigned PER_W  = 32,
    parameter int unsigned CLKP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic [TIME_W-1:0] time_now,
    input  logic              start,
    input  logic              stop,
    input  logic [TIME_W-1:0] alarm,
    input  logic [PER_W-1:0]  period,
    input  logic [CLKP_W-1:0] clk_period,
    output logic              pulse_o,
    output logic              fire_o
);

    typedef struct packed {
        logic              active;
        logic              pulse;
        logic              fire;
        logic [TIME_W-1:0] next_edge;
    } chan_t;

    chan_t             st_d, st_q;
    logic [TIME_W-1:0] step;

    always_comb begin
        step       = TIME_W'(period) + TIME_W'(clk_period);
        st_d       = st_q;
        st_d.fire  = 1'b0;
        if (stop) begin
            st_d.active = 1'b0;
            st_d.pulse  = 1'b0;
        end else if (start) begin
            st_d.active    = 1'b1;
            st_d.pulse     = 1'b1;
            st_d.fire      = 1'b1;
            st_d.next_edge = alarm + step;
        end else if (cnt_tick) begin
            if (st_q.active && (time_now >= st_q.next_edge)) begin
                st_d.pulse     = 1'b1;
                st_d.fire      = 1'b1;
                st_d.next_edge = st_q.next_edge + step;
            end else begin
                st_d.pulse = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign fire_o  = st_q.fire;

endmodule

// File: rtl/alarm_pulse_gen.sv
module alarm_pulse_gen
    import apg_pkg::*;
#(
    parameter int unsigned NUM_PULSE = 2,
    parameter int unsigned PER_W     = 32,
    parameter int unsigned CLKP_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [63:0]          time_now,
    input  logic                 cnt_tick,
    input  logic                 time_jump,
    input  logic [CLKP_W-1:0]    clk_period,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [31:0]          wr_data,
    output logic [NUM_PULSE-1:0] pulse_o,
    output logic                 pulse_ev_o
);

    logic [TIME_W-1:0]               alarm;
    logic                            enable;
    logic [NUM_PULSE-1:0][PER_W-1:0] period;
    logic                            lo_wr;
    logic                            hi_wr;
    logic                            start;
    logic                            stop;
    logic [NUM_PULSE-1:0]            fire;

    apg_regs #(.NUM_PULSE(NUM_PULSE), .PER_W(PER_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .alarm_o  (alarm),
        .enable_o (enable),
        .period_o (period),
        .lo_wr_o  (lo_wr),
        .hi_wr_o  (hi_wr)
    );

    apg_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_tick  (cnt_tick),
        .time_now  (time_now),
        .time_jump (time_jump),
        .enable    (enable),
        .alarm     (alarm),
        .lo_wr     (lo_wr),
        .hi_wr     (hi_wr),
        .start_o   (start),
        .stop_o    (stop)
    );

    for (genvar g = 0; g < int'(NUM_PULSE); g++) begin : g_chan
        apg_chan #(.PER_W(PER_W), .CLKP_W(CLKP_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_tick   (cnt_tick),
            .time_now   (time_now),
            .start      (start),
            .stop       (stop),
            .alarm      (alarm),
            .period     (period[g]),
            .clk_period (clk_period),
            .pulse_o    (pulse_o[g]),
            .fire_o     (fire[g])
        );
    end

    assign pulse_ev_o = fire[0];

endmodule

// File: rtl/apg_checker.sv
module apg_checker #(
    parameter int unsigned NUM_PULSE = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_tick,
    input logic                 time_jump,
    input logic                 wr_en,
    input logic [2:0]           wr_sel,
    input logic                 ctrl_bit,
    input logic [NUM_PULSE-1:0] pulse_o,
    input logic                 pulse_ev_o
);

    // R8: a time jump silences every generator
    p_jump_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        time_jump |=> (pulse_o == '0));

    // R8: a start-time write silences every generator
    p_alarm_wr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 3'd0 || wr_sel == 3'd1)) |=> (pulse_o == '0));

    // R9: clearing enable silences outputs two cycles later
    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd2 && !ctrl_bit) |=> ##1 (pulse_o == '0));

    // R5: outputs hold without tick, jump or write
    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !time_jump && !wr_en && !$past(wr_en)) |=> $stable(pulse_o));

    // R6: event only together with generator 0 pulse
    p_ev_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_ev_o |-> pulse_o[0]);

    // R6: event follows a counter tick
    p_ev_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_ev_o |-> $past(cnt_tick));

    // R3: a pulse rises only after a counter tick
    p_rise_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o[0]) |-> $past(cnt_tick));

endmodule

bind alarm_pulse_gen apg_checker #(.NUM_PULSE(NUM_PULSE)) u_apg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .time_jump  (time_jump),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .ctrl_bit   (wr_data[0]),
    .pulse_o    (pulse_o),
    .pulse_ev_o (pulse_ev_o)
);

// File: tb/test_alarm_pulse_gen.sv
`timescale 1ns/1ps
module test_alarm_pulse_gen;

    localparam int NP   = 3;
    localparam int CLKP = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] time_now;
    logic        cnt_tick, time_jump, wr_en;
    logic [7:0]  clk_period;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic [NP-1:0] pulse_o;
    logic        pulse_ev_o;

    alarm_pulse_gen #(.NUM_PULSE(NP), .PER_W(32), .CLKP_W(8)) i_alarm_pulse_gen (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .cnt_tick(cnt_tick),
        .time_jump(time_jump), .clk_period(clk_period), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pulse_o(pulse_o), .pulse_ev_o(pulse_ev_o)
    );

    always #2 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    logic [31:0] m_alo, m_ahi, m_per [NP];
    logic        m_en, m_armed, m_ev;
    logic        m_act [NP], m_pulse [NP];
    logic [63:0] m_next [NP];
    logic [63:0] tnow;
    logic [NP-1:0] prev_p;
    int          rises [NP];

    function automatic logic [NP-1:0] m_pvec();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = m_pulse[i];
        return v;
    endfunction

    function automatic logic [63:0] m_step(input int i);
        return 64'(m_per[i]) + 64'(CLKP);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one cycle: compare, drive, advance model
    task automatic cyc(input bit tk, input bit jp, input logic [63:0] jv,
                       input bit we, input logic [2:0] sl, input logic [31:0] dt);
        logic stop, start;
        logic [63:0] alm;
        @(negedge clk);
        chk(pulse_o == m_pvec(), tag, 64'(pulse_o), 64'(m_pvec()));
        chk(pulse_ev_o == m_ev, "R6", 64'(pulse_ev_o), 64'(m_ev));
        for (int i = 0; i < NP; i++) if (pulse_o[i] && !prev_p[i]) rises[i]++;
        prev_p = pulse_o;
        if (jp) tnow = jv; else if (tk) tnow = tnow + 64'(CLKP);
        time_now = tnow; cnt_tick = tk; time_jump = jp;
        wr_en = we; wr_sel = sl; wr_data = dt;
        alm   = {m_ahi, m_alo};
        stop  = jp || (we && (sl == 3'd0 || sl == 3'd1)) || !m_en;
        start = m_armed && !stop && tk && (tnow >= alm);
        m_ev  = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (stop) begin
                m_act[i] = 0; m_pulse[i] = 0;
            end else if (start) begin
                m_act[i] = 1; m_pulse[i] = 1; m_next[i] = alm + m_step(i);
                if (i == 0) m_ev = 1;
            end else if (tk) begin
                if (m_act[i] && tnow >= m_next[i]) begin
                    m_pulse[i] = 1; m_next[i] = m_next[i] + m_step(i);
                    if (i == 0) m_ev = 1;
                end else m_pulse[i] = 0;
            end
        end
        if (jp) m_armed = 0;
        else if (we && sl == 3'd1) m_armed = 1;
        else if (we && sl == 3'd0) m_armed = 0;
        else if (start) m_armed = 0;
        if (we) begin
            case (sl)
                3'd0: m_alo = dt;
                3'd1: m_ahi = dt;
                3'd2: m_en  = dt[0];
                default: if (int'(sl) - 3 < NP) m_per[int'(sl) - 3] = dt;
            endcase
        end
    endtask

    task automatic run(input int n, input int pct);
        for (int k = 0; k < n; k++) cyc($urandom_range(99) < pct, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input logic [2:0] sl, input logic [31:0] dt);
        cyc($urandom_range(99) < 80, 0, 0, 1, sl, dt);
    endtask

    task automatic set_alarm(input logic [63:0] a);
        wr(3'd0, a[31:0]);
        wr(3'd1, a[63:32]);
    endtask

    task automatic clr_rises();
        for (int i = 0; i < NP; i++) rises[i] = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; cnt_tick = 0; time_jump = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        clk_period = 8'(CLKP);
        tnow = 64'h0000_0000_FFFF_F000; time_now = tnow;
        m_alo = 0; m_ahi = 0; m_en = 0; m_armed = 0; m_ev = 0; prev_p = '0;
        for (int i = 0; i < NP; i++) begin
            m_per[i] = 0; m_act[i] = 0; m_pulse[i] = 0; m_next[i] = 0;
        end
        clr_rises();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        tag = "R1";
        run(4, 0);

        // R2 R3 R4 R7: start time past a 32-bit word boundary
        tag = "R3/R4/R7";
        wr(3'd3, 200 - CLKP);
        wr(3'd4, 320 - CLKP);
        wr(3'd5, 480 - CLKP);
        wr(3'd2, 32'd1);
        set_alarm(64'h0000_0001_0000_0040);
        clr_rises();
        run(1100, 80);
        chk(rises[0] > 2, "R3", 64'(rises[0]), 3);
        chk(rises[1] > 1, "R4", 64'(rises[1]), 2);
        chk(rises[2] > 0, "R7", 64'(rises[2]), 1);

        // R10: period change mid-run
        tag = "R10";
        wr(3'd3, 96 - CLKP);
        run(300, 80);

        // R8: time jump silences and keeps silent
        tag = "R8";
        cyc(1, 1, tnow + 64'd5000, 0, 0, 0);
        clr_rises();
        run(150, 90);
        chk(rises[0] == 0 && rises[1] == 0 && rises[2] == 0, "R8",
            64'(rises[0] + rises[1] + rises[2]), 0);

        // R2: low write alone does not arm
        tag = "R2";
        wr(3'd0, 32'(tnow) + 32'd100);
        clr_rises();
        run(80, 90);
        chk(rises[0] == 0, "R2", 64'(rises[0]), 0);
        wr(3'd1, tnow[63:32]);
        run(300, 80);

        // R9: disabled block keeps a past start time until enabled
        tag = "R9";
        wr(3'd2, 32'd0);
        run(10, 80);
        set_alarm(tnow);
        clr_rises();
        run(60, 90);
        chk(rises[0] == 0, "R9", 64'(rises[0]), 0);
        wr(3'd2, 32'd1);
        run(20, 100);
        chk(rises[0] > 0, "R9", 64'(rises[0]), 1);
        run(200, 80);

        // R5 R6 R8: random mix
        tag = "R5/R8";
        for (int it = 0; it < 60; it++) begin
            case ($urandom_range(5))
                0: wr(3'($urandom_range(5, 3)), 32'($urandom_range(400, 0)));
                1: set_alarm(tnow + 64'($urandom_range(600, 0)));
                2: cyc($urandom_range(1), 1, tnow + 64'($urandom_range(3000, 0)), 0, 0, 0);
                3: wr(3'd2, 32'($urandom_range(9) != 0));
                default: ;
            endcase
            run($urandom_range(120, 20), $urandom_range(95, 40));
        end
        run(2, 0);
        done = 1;
        finish_run();
    end

endmodule